// File: doc/BRIEF.md
# Vectored Two-Level Interrupt Controller

The block gathers 32 interrupt sources into a pending-status register and steers every enabled pending source to one of two outputs: a normal interrupt line and a critical interrupt line. Each source is chosen as edge or level sensitive. Software reaches the controller through a small register port with a write strobe, a read strobe, a 4-bit offset and 32-bit data. Through this port it sets and clears pending bits, enables sources, marks sources as critical and chooses the trigger mode.

For critical sources the block also provides a vector address, built from a programmable base. The base is extended by a fixed 512-byte step for each priority position of the first pending critical source. The scan runs up from bit 0 or down from bit 31, and software picks the direction. The outputs and the vector are registered, so the effect of an input change or a register write is visible one clock later.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset every register reads zero, and irq_out and crit_out are low.
- R2: Input n maps to status bit 31-n. With its trigger bit at 1 (edge), a low-to-high input change sets the status bit. The bit stays set after the input falls, until software clears it.
- R3: With its trigger bit at 0 (level), the status bit is set when the input rises and cleared when the input falls. Reads show the change after the next rising clock edge.
- R4: A write to offset 0 clears the status bits where the data is 1. In the same cycle, every level-sensitive input that is high sets its bit again.
- R5: A write to offset 1 sets the status bits where the data is 1. Offset 2 is enable, 3 is critical select, 4 is polarity and 5 is trigger, and each reads back the value written.
- R6: Offset 6 reads status AND enable. Writes to offset 6 and offset 7 change no register.
- R7: irq_out is high when status AND enable AND NOT critical is nonzero. crit_out is high when status AND enable AND critical is nonzero. Both outputs update at the clock edge that takes the change.
- R8: Offset 8 holds the vector configuration, and offset 7 reads the vector. With configuration bit 0 at 0, the vector is the configuration with bits 1:0 cleared, plus 512 times the index of the lowest pending critical status bit.
- R9: With configuration bit 0 at 1, the vector is the configuration with bits 1:0 cleared, plus 512 times (31 minus the index of the highest pending critical status bit).
- R10: A write to offset 8 stores the data with bit 1 forced to 0. The vector reads zero while no critical source is pending.
- R11: Polarity is stored and has no effect on status or outputs. Offsets 9 to 15 read zero, and reg_rdata is zero while reg_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Interrupt sources, already synchronous to clk |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| irq_out | output | 1 | Normal interrupt request |
| crit_out | output | 1 | Critical interrupt request |

## Verification
Directed cases first separate edge from level behaviour. A pulse on an edge source must leave its bit latched. The same pulse on a level source must vanish again, and a full clear while a level input is high must leave only that bit. The vector is then driven with several pending critical bits in both scan directions, which shows whether the lowest or the highest bit is chosen and whether the step is counted from the correct end. Long random runs then toggle sparse inputs and mix writes to every offset, including undefined ones. These runs exercise a rising edge that coincides with a clear, trigger-mode changes while sources are active, and writes to the read-only offsets, all against a cycle model held in the bench.

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter bit HAS_VECTORS = 1'b1,
  parameter int STRIDE_LOG2 = 9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] irq_in,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq_out,
  output logic        crit_out
);
  localparam int W  = 32;
  localparam int PW = $clog2(W);

  localparam logic [3:0] A_STAT = 4'd0;
  localparam logic [3:0] A_SET  = 4'd1;
  localparam logic [3:0] A_EN   = 4'd2;
  localparam logic [3:0] A_CRIT = 4'd3;
  localparam logic [3:0] A_POL  = 4'd4;
  localparam logic [3:0] A_TRIG = 4'd5;
  localparam logic [3:0] A_MSK  = 4'd6;
  localparam logic [3:0] A_VEC  = 4'd7;
  localparam logic [3:0] A_VCFG = 4'd8;

  logic [W-1:0] status_q, en_q, cmask_q, pol_q, trig_q, vcfg_q, vec_q, prev_q;
  logic [W-1:0] status_d, en_d, cmask_d, trig_d, vcfg_d, vec_d;
  logic [W-1:0] src, rise, fall, lvl, crit_pend;
  logic [PW-1:0] pos;
  logic irq_q, cint_q;

  for (genvar g = 0; g < W; g++) begin : g_map
    assign src[W-1-g] = irq_in[g];
  end

  assign rise = src & ~prev_q;
  assign fall = ~src & prev_q;
  assign lvl  = src & ~trig_q;

  always_comb begin
    status_d = status_q;
    if (reg_wr && reg_addr == A_STAT) status_d = (status_d & ~reg_wdata) | lvl;
    if (reg_wr && reg_addr == A_SET)  status_d = status_d | reg_wdata;
    status_d = (status_d | rise) & ~(fall & ~trig_q);
  end

  assign en_d    = (reg_wr && reg_addr == A_EN)   ? reg_wdata : en_q;
  assign cmask_d = (reg_wr && reg_addr == A_CRIT) ? reg_wdata : cmask_q;
  assign trig_d  = (reg_wr && reg_addr == A_TRIG) ? reg_wdata : trig_q;
  assign vcfg_d  = (HAS_VECTORS && reg_wr && reg_addr == A_VCFG) ? (reg_wdata & ~32'h2) : vcfg_q;

  assign crit_pend = status_d & en_d & cmask_d;

  always_comb begin
    pos = '0;
    if (!vcfg_d[0]) begin
      for (int i = W - 1; i >= 0; i--) if (crit_pend[i]) pos = PW'(i);
    end else begin
      for (int i = 0; i < W; i++) if (crit_pend[i]) pos = PW'(W - 1 - i);
    end
  end

  assign vec_d = (HAS_VECTORS && |crit_pend)
               ? ({vcfg_d[W-1:2], 2'b00} + ({{(W-PW){1'b0}}, pos} << STRIDE_LOG2))
               : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      en_q     <= '0;
      cmask_q  <= '0;
      pol_q    <= '0;
      trig_q   <= '0;
      vcfg_q   <= '0;
      vec_q    <= '0;
      prev_q   <= '0;
      irq_q    <= 1'b0;
      cint_q   <= 1'b0;
    end else begin
      status_q <= status_d;
      en_q     <= en_d;
      cmask_q  <= cmask_d;
      trig_q   <= trig_d;
      vcfg_q   <= vcfg_d;
      vec_q    <= vec_d;
      prev_q   <= src;
      irq_q    <= |(status_d & en_d & ~cmask_d);
      cint_q   <= |crit_pend;
      if (reg_wr && reg_addr == A_POL) pol_q <= reg_wdata;
    end
  end

  assign irq_out  = irq_q;
  assign crit_out = cint_q;

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      unique case (reg_addr)
        A_STAT, A_SET: reg_rdata = status_q;
        A_EN:          reg_rdata = en_q;
        A_CRIT:        reg_rdata = cmask_q;
        A_POL:         reg_rdata = pol_q;
        A_TRIG:        reg_rdata = trig_q;
        A_MSK:         reg_rdata = status_q & en_q;
        A_VEC:         reg_rdata = HAS_VECTORS ? vec_q : '0;
        A_VCFG:        reg_rdata = HAS_VECTORS ? vcfg_q : '0;
        default:       reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/vec_irq_ctrl_chk.sv
module vec_irq_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [3:0]  reg_addr,
  input logic        irq_out,
  input logic        crit_out,
  input logic [31:0] status_q,
  input logic [31:0] en_q,
  input logic [31:0] cmask_q,
  input logic [31:0] trig_q,
  input logic [31:0] vcfg_q,
  input logic [31:0] vec_q
);
  assert_irq_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == |(status_q & en_q & ~cmask_q));

  assert_crit_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    crit_out == |(status_q & en_q & cmask_q));

  assert_vec_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !crit_out |-> vec_q == 32'h0);

  assert_cfg_bit1_R10: assert property (@(posedge clk) disable iff (!rst_n)
    vcfg_q[1] == 1'b0);

  assert_vec_align_R8: assert property (@(posedge clk) disable iff (!rst_n)
    crit_out |-> vec_q[1:0] == 2'b00);

  assert_ro_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_addr == 4'd6 || reg_addr == 4'd7)) |=>
      ($stable(en_q) && $stable(cmask_q) && $stable(trig_q) && $stable(vcfg_q)));
endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .irq_out(irq_out), .crit_out(crit_out), .status_q(status_q), .en_q(en_q),
  .cmask_q(cmask_q), .trig_q(trig_q), .vcfg_q(vcfg_q), .vec_q(vec_q)
);

// File: tb/sim_vec_irq_ctrl.sv
`timescale 1ns/1ps
module sim_vec_irq_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq_out, crit_out;

  int checks = 0, errors = 0;
  logic [31:0] m_st = '0, m_en = '0, m_cr = '0, m_pol = '0, m_tr = '0, m_cfg = '0, m_prev = '0;

  always #10 clk = ~clk;

  vec_irq_ctrl u0 (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out), .crit_out(crit_out));

  function automatic logic [31:0] rev(input logic [31:0] v);
    for (int i = 0; i < 32; i++) rev[31-i] = v[i];
  endfunction

  function automatic logic [31:0] exp_vec(input logic [31:0] cp, input logic [31:0] cfg);
    exp_vec = '0;
    if (cp != 0) begin
      if (!cfg[0]) begin
        for (int i = 31; i >= 0; i--) if (cp[i]) exp_vec = (cfg & ~32'h3) + 32'(i) * 512;
      end else begin
        for (int i = 0; i < 32; i++) if (cp[i]) exp_vec = (cfg & ~32'h3) + 32'(31 - i) * 512;
      end
    end
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    reg_addr = a; reg_rd = 1'b1; #1; v = reg_rdata; reg_rd = 1'b0; #1;
  endtask

  task automatic cycle(input logic [31:0] inv, input logic wr, input logic [3:0] a, input logic [31:0] d);
    logic [31:0] s, m, rs, lv;
    @(negedge clk);
    irq_in = inv; reg_wr = wr; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    m = rev(inv); lv = m & ~m_tr; s = m_st;
    if (wr && a == 4'd0) s = (s & ~d) | lv;
    if (wr && a == 4'd1) s = s | d;
    rs = m & ~m_prev;
    s = (s | rs) & ~(~m & m_prev & ~m_tr);
    m_st = s; m_prev = m;
    if (wr) case (a)
      4'd2: m_en = d;
      4'd3: m_cr = d;
      4'd4: m_pol = d;
      4'd5: m_tr = d;
      4'd8: m_cfg = d & ~32'h2;
      default: ;
    endcase
    #2 reg_wr = 1'b0;
  endtask

  task automatic check_state(input string tag);
    logic [31:0] v;
    chk({tag, " irq_out"}, 32'(irq_out), 32'(|(m_st & m_en & ~m_cr)));
    chk({tag, " crit_out"}, 32'(crit_out), 32'(|(m_st & m_en & m_cr)));
    rd(4'd0, v); chk({tag, " status"}, v, m_st);
    rd(4'd6, v); chk({tag, " masked"}, v, m_st & m_en);
    rd(4'd7, v); chk({tag, " vector"}, v, exp_vec(m_st & m_en & m_cr, m_cfg));
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] v, inv;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R1: reset state
    for (int a = 0; a < 9; a++) begin
      rd(4'(a), v); chk("R1 reset register", v, 32'h0);
    end
    chk("R1 irq_out", 32'(irq_out), 0);
    chk("R1 crit_out", 32'(crit_out), 0);

    // R2: edge source, input 0 -> bit 31
    cycle('0, 1, 4'd5, 32'hFFFF_FFFF);
    cycle('0, 1, 4'd2, 32'hFFFF_FFFF);
    cycle(32'h1, 0, 0, 0);
    rd(4'd0, v); chk("R2 edge set bit31", v, 32'h8000_0000);
    chk("R2 irq_out", 32'(irq_out), 1);
    cycle('0, 0, 0, 0);
    rd(4'd0, v); chk("R2 edge held", v, 32'h8000_0000);
    cycle('0, 1, 4'd0, 32'h8000_0000);
    rd(4'd0, v); chk("R2 cleared", v, 32'h0);

    // R3: level source, input 3 -> bit 28
    cycle('0, 1, 4'd5, 32'h0);
    cycle(32'h8, 0, 0, 0);
    rd(4'd0, v); chk("R3 level set", v, 32'h1000_0000);
    cycle('0, 0, 0, 0);
    rd(4'd0, v); chk("R3 level fall", v, 32'h0);

    // R4: clear re-asserts active level input, edge bit cleared
    cycle(32'h20, 1, 4'd5, 32'h0000_FFFF);
    cycle(32'h20, 1, 4'd1, 32'h0000_0300);
    rd(4'd0, v); chk("R4 before clear", v, 32'h0400_0300);
    cycle(32'h20, 1, 4'd0, 32'hFFFF_FFFF);
    rd(4'd0, v); chk("R4 level kept", v, 32'h0400_0000);

    // R5 / R6 / R11
    cycle(32'h20, 1, 4'd1, 32'h0000_00F0);
    rd(4'd0, v); chk("R5 status set", v, 32'h0400_00F0);
    cycle(32'h20, 1, 4'd6, 32'h1234_5678);
    cycle(32'h20, 1, 4'd7, 32'hDEAD_BEEF);
    rd(4'd2, v); chk("R6 enable untouched", v, 32'hFFFF_FFFF);
    rd(4'd5, v); chk("R5 trig readback", v, 32'h0000_FFFF);
    cycle(32'h20, 1, 4'd2, 32'h0000_00F0);
    rd(4'd6, v); chk("R6 masked", v, 32'h0000_00F0);
    cycle(32'h20, 1, 4'd4, 32'hA5A5_0000);
    rd(4'd4, v); chk("R11 polarity stored", v, 32'hA5A5_0000);
    chk("R11 irq unaffected", 32'(irq_out), 1);
    rd(4'd9, v); chk("R11 offset9", v, 0);
    rd(4'd15, v); chk("R11 offset15", v, 0);
    reg_addr = 4'd2; #1; chk("R11 no rd strobe", reg_rdata, 0);

    // R7 / R8 / R9 / R10: critical bits 4..7 pending
    cycle(32'h20, 1, 4'd3, 32'h0000_00B0);
    chk("R7 crit_out", 32'(crit_out), 1);
    chk("R7 irq_out from bit6", 32'(irq_out), 1);
    cycle(32'h20, 1, 4'd8, 32'h0001_0003);
    rd(4'd8, v); chk("R10 bit1 forced", v, 32'h0001_0001);
    rd(4'd7, v); chk("R9 descending", v, 32'h0001_0000 + 24 * 512);
    cycle(32'h20, 1, 4'd8, 32'h0002_0000);
    rd(4'd7, v); chk("R8 ascending", v, 32'h0002_0000 + 4 * 512);
    cycle(32'h20, 1, 4'd3, 32'h0);
    rd(4'd7, v); chk("R10 vector zero", v, 0);
    chk("R7 crit low", 32'(crit_out), 0);
    check_state("R7 directed");

    // random phase
    inv = 32'h20;
    for (int n = 0; n < 3000; n++) begin
      logic w; logic [3:0] a; logic [31:0] d;
      inv ^= ($urandom & $urandom & $urandom & $urandom);
      w = ($urandom_range(0, 3) == 0);
      a = 4'($urandom_range(0, 10));
      d = $urandom;
      if (a == 4'd0) d = d | $urandom;
      cycle(inv, w, a, d);
      check_state("R2 R3 R4 R5 R7 R8 R9 random");
      if (n % 50 == 0) begin
        rd(4'd8, v); chk("R10 cfg random", v, m_cfg);
        rd(4'd3, v); chk("R5 crit random", v, m_cr);
        rd(4'd4, v); chk("R11 pol random", v, m_pol);
      end
    end
    summary();
  end
endmodule